// File: doc/BRIEF.md
# Operand Bypass Selector

This block is the execute-stage bypass network of a five-stage load/store pipeline. Each ALU operand comes from an instruction whose two source register numbers and register-file read values sit in the decode/execute pipeline register. Two older instructions may still hold a result that has not yet been written back. One sits one stage ahead (the memory-stage producer), the other two stages ahead (the write-back-stage producer). For each operand the block decides whether the register-file value is stale. If it is, the block substitutes the newest pending result.

The block is purely combinational. It compares each source number against each producer's destination number, qualified by the producer's write enable and by the rule that register 0 is never a forwarding target. It emits a 2-bit select code per operand and the resulting operand value. Hazard stalling, the ALU, the register file and the pipeline registers belong to the surrounding pipeline.

Top module: `fwd_unit`

## Requirements
- R1: With both producer write enables low, both select codes are 00 and each operand equals its register-file value.
- R2: When the memory-stage producer writes (enable high), its destination is non-zero and equals the first source number, select A is 10 and operand A equals the memory-stage result.
- R3: The same memory-stage test against the second source number gives select B 10 and operand B equal to the memory-stage result.
- R4: When the write-back-stage producer writes, its destination is non-zero and equals an operand's source number, and R2/R3 do not apply to that operand, that operand's select is 01 and its value is the write-back-stage result.
- R5: A producer whose destination is register 0 is never forwarded; an operand whose source is register 0 always takes select 00 and the register-file value.
- R6: A producer with its write enable low is never forwarded, even when its destination matches.
- R7: When both producers match the same operand, the memory-stage (newer) result wins with select 10.
- R8: The two operands are resolved independently, so operand A may take the memory-stage result while operand B takes the write-back-stage result, and the reverse.
- R9: Select code 11 is never produced on either select output.
- R10: Outputs follow input changes within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the executing instruction |
| src_b_idx | input | 5 | Second source register number of the executing instruction |
| rf_a_val | input | 32 | Register-file read value for operand A |
| rf_b_val | input | 32 | Register-file read value for operand B |
| exm_wen | input | 1 | Memory-stage producer writes a register |
| exm_dst | input | 5 | Memory-stage producer destination number |
| exm_val | input | 32 | Memory-stage producer result |
| mwb_wen | input | 1 | Write-back-stage producer writes a register |
| mwb_dst | input | 5 | Write-back-stage producer destination number |
| mwb_val | input | 32 | Write-back-stage producer result |
| sel_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back stage |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | 32 | Forwarded operand A |
| opnd_b | output | 32 | Forwarded operand B |

## Verification
No register lies on any path, so every select code and operand is due in the cycle its inputs are presented, with zero cycles of latency. The bench applies each input set just after a rising edge. It compares all four outputs with a behavioural model at the following falling edge, within the same cycle and before the next set arrives. That window is where R10 is checked. Directed vectors cover each requirement, and pseudo-random vectors drawn from a small register-number range produce frequent matches, double matches and register-0 cases.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10,
    SEL_RSV = 2'b11
  } fwd_sel_e;

  // Priority resolution: newer producer first, older second, register file last.
  function automatic fwd_sel_e resolve_sel(input logic exm_hit, input logic mwb_hit);
    fwd_sel_e s;
    if (exm_hit)      s = SEL_EXM;
    else if (mwb_hit) s = SEL_MWB;
    else              s = SEL_RF;
    return s;
  endfunction

endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect #(
  parameter int REG_AW = 5
) (
  input  logic              wen,
  input  logic [REG_AW-1:0] dst,
  input  logic [REG_AW-1:0] src,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  function automatic logic producer_matches(input logic w,
                                            input logic [REG_AW-1:0] d,
                                            input logic [REG_AW-1:0] s);
    return w && (d != ZERO_REG) && (d == s);
  endfunction

  assign hit = producer_matches(wen, dst, src);
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_sel_e          sel,
  input  logic [XLEN-1:0]   rf_val,
  input  logic [XLEN-1:0]   exm_val,
  input  logic [XLEN-1:0]   mwb_val,
  output logic [XLEN-1:0]   out_val
);
  always_comb begin
    unique case (sel)
      SEL_EXM: out_val = exm_val;
      SEL_MWB: out_val = mwb_val;
      default: out_val = rf_val;   // SEL_RF and the unused code
    endcase
  end
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [XLEN-1:0]   rf_val,
  input  logic              exm_wen,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic [XLEN-1:0]   exm_val,
  input  logic              mwb_wen,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic [XLEN-1:0]   mwb_val,
  output fwd_sel_e          sel,
  output logic [XLEN-1:0]   out_val
);
  logic exm_hit;
  logic mwb_hit;

  fwd_hit_detect #(.REG_AW(REG_AW)) i_exm_hit (
    .wen(exm_wen), .dst(exm_dst), .src(src), .hit(exm_hit)
  );

  fwd_hit_detect #(.REG_AW(REG_AW)) i_mwb_hit (
    .wen(mwb_wen), .dst(mwb_dst), .src(src), .hit(mwb_hit)
  );

  assign sel = resolve_sel(exm_hit, mwb_hit);

  fwd_operand_mux #(.XLEN(XLEN)) i_mux (
    .sel(sel), .rf_val(rf_val), .exm_val(exm_val), .mwb_val(mwb_val), .out_val(out_val)
  );
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_a_idx,
  input  logic [REG_AW-1:0] src_b_idx,
  input  logic [XLEN-1:0]   rf_a_val,
  input  logic [XLEN-1:0]   rf_b_val,
  input  logic              exm_wen,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic [XLEN-1:0]   exm_val,
  input  logic              mwb_wen,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic [XLEN-1:0]   mwb_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [XLEN-1:0]   opnd_a,
  output logic [XLEN-1:0]   opnd_b
);
  localparam int NUM_OPND = 2;

  logic [REG_AW-1:0] lane_src [NUM_OPND];
  logic [XLEN-1:0]   lane_rf  [NUM_OPND];
  logic [XLEN-1:0]   lane_out [NUM_OPND];
  fwd_sel_e          lane_sel [NUM_OPND];

  assign lane_src[0] = src_a_idx;
  assign lane_src[1] = src_b_idx;
  assign lane_rf[0]  = rf_a_val;
  assign lane_rf[1]  = rf_b_val;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_lane
    fwd_lane #(.XLEN(XLEN), .REG_AW(REG_AW)) i_lane (
      .src(lane_src[g]), .rf_val(lane_rf[g]),
      .exm_wen(exm_wen), .exm_dst(exm_dst), .exm_val(exm_val),
      .mwb_wen(mwb_wen), .mwb_dst(mwb_dst), .mwb_val(mwb_val),
      .sel(lane_sel[g]), .out_val(lane_out[g])
    );
  end

  assign sel_a  = lane_sel[0];
  assign sel_b  = lane_sel[1];
  assign opnd_a = lane_out[0];
  assign opnd_b = lane_out[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] src_a_idx,
  input logic [REG_AW-1:0] src_b_idx,
  input logic [XLEN-1:0]   rf_a_val,
  input logic [XLEN-1:0]   rf_b_val,
  input logic              exm_wen,
  input logic [REG_AW-1:0] exm_dst,
  input logic [XLEN-1:0]   exm_val,
  input logic              mwb_wen,
  input logic [REG_AW-1:0] mwb_dst,
  input logic [XLEN-1:0]   mwb_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [XLEN-1:0]   opnd_a,
  input logic [XLEN-1:0]   opnd_b
);
  always_comb begin
    AST_NO_CODE11_A: assert (sel_a != 2'b11) else $error("sel_a reserved code"); // R9
    AST_NO_CODE11_B: assert (sel_b != 2'b11) else $error("sel_b reserved code"); // R9
    AST_IDLE_RF: assert ((exm_wen || mwb_wen) || (sel_a == 2'b00 && sel_b == 2'b00 &&
                         opnd_a == rf_a_val && opnd_b == rf_b_val))
      else $error("idle not from register file"); // R1
    AST_ZERO_SRC_A: assert (src_a_idx != '0 || (sel_a == 2'b00 && opnd_a == rf_a_val))
      else $error("register 0 forwarded on A"); // R5
    AST_ZERO_SRC_B: assert (src_b_idx != '0 || (sel_b == 2'b00 && opnd_b == rf_b_val))
      else $error("register 0 forwarded on B"); // R5
    AST_NEWEST_A: assert (!(exm_wen && exm_dst != '0 && exm_dst == src_a_idx) || sel_a == 2'b10)
      else $error("memory-stage match lost on A"); // R7
    AST_NEWEST_B: assert (!(exm_wen && exm_dst != '0 && exm_dst == src_b_idx) || sel_b == 2'b10)
      else $error("memory-stage match lost on B"); // R3
    AST_VAL_EXM_A: assert (sel_a != 2'b10 || opnd_a == exm_val) else $error("A value"); // R2
    AST_VAL_MWB_A: assert (sel_a != 2'b01 || opnd_a == mwb_val) else $error("A value"); // R4
    AST_VAL_MWB_B: assert (sel_b != 2'b01 || opnd_b == mwb_val) else $error("B value"); // R4
    AST_NOWEN_MWB: assert (mwb_wen || (sel_a != 2'b01 && sel_b != 2'b01))
      else $error("disabled producer forwarded"); // R6
  end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) i_chk (.*);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [4:0]  src_a_idx, src_b_idx, exm_dst, mwb_dst;
  logic [31:0] rf_a_val, rf_b_val, exm_val, mwb_val;
  logic        exm_wen, mwb_wen;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int total = 0;
  int bad   = 0;

  fwd_unit i_fwd_unit (.*);

  // Behavioural model: producers listed newest first, first qualifying one wins.
  function automatic void model(input logic [4:0] src, input logic [31:0] rf,
                                output logic [1:0] s, output logic [31:0] v);
    logic [1:0]  codes [$];
    logic [31:0] vals  [$];
    logic        ens   [$];
    logic [4:0]  dsts  [$];
    codes = '{2'b10, 2'b01};
    vals  = '{exm_val, mwb_val};
    ens   = '{exm_wen, mwb_wen};
    dsts  = '{exm_dst, mwb_dst};
    s = 2'b00; v = rf;
    for (int k = 0; k < 2; k++) begin
      if (ens[k] && dsts[k] != 0 && dsts[k] == src) begin
        s = codes[k]; v = vals[k];
        break;
      end
    end
  endfunction

  task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                       input logic ew, input logic [4:0] ed,
                       input logic mw, input logic [4:0] md);
    @(posedge clk); #1;
    src_a_idx = sa; src_b_idx = sb;
    exm_wen = ew; exm_dst = ed; mwb_wen = mw; mwb_dst = md;
    rf_a_val = $urandom; rf_b_val = $urandom;
    exm_val = $urandom; mwb_val = $urandom;
  endtask

  // Sampled at the falling edge of the same cycle the inputs were applied (R10).
  task automatic check(input string req);
    logic [1:0]  es_a, es_b;
    logic [31:0] ev_a, ev_b;
    @(negedge clk);
    model(src_a_idx, rf_a_val, es_a, ev_a);
    model(src_b_idx, rf_b_val, es_b, ev_b);
    total++;
    if (sel_a !== es_a || opnd_a !== ev_a || sel_b !== es_b || opnd_b !== ev_b) begin
      bad++;
      $display("FAIL %s: sel_a=%b opnd_a=%h sel_b=%b opnd_b=%h expected %b %h %b %h",
               req, sel_a, opnd_a, sel_b, opnd_b, es_a, ev_a, es_b, ev_b);
    end
    total++;
    if (sel_a == 2'b11 || sel_b == 2'b11) begin
      bad++;
      $display("FAIL R9: sel_a=%b sel_b=%b expected neither 11", sel_a, sel_b);
    end
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_up();
  end

  initial begin
    drive(5'd3, 5'd4, 1'b0, 5'd3, 1'b0, 5'd4);  check("R1 idle");
    drive(5'd7, 5'd2, 1'b1, 5'd7, 1'b0, 5'd0);  check("R2 exm to A");
    drive(5'd1, 5'd9, 1'b1, 5'd9, 1'b0, 5'd0);  check("R3 exm to B");
    drive(5'd6, 5'd6, 1'b0, 5'd6, 1'b1, 5'd6);  check("R4 mwb both");
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);  check("R5 zero reg");
    drive(5'd0, 5'd5, 1'b1, 5'd0, 1'b1, 5'd5);  check("R5 zero exm, mwb B");
    drive(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8);  check("R6 no enable");
    drive(5'd12, 5'd13, 1'b1, 5'd12, 1'b1, 5'd12); check("R7 exm wins");
    drive(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1);  check("R7 exm wins both");
    drive(5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 5'd11); check("R8 A exm B mwb");
    drive(5'd11, 5'd10, 1'b1, 5'd10, 1'b1, 5'd11); check("R8 A mwb B exm");
    drive(5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31); check("R2 R3 top reg");
    for (int i = 0; i < 400; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)));
      check("R2 R4 R7 R8 random");
    end
    finish_up();
  end
endmodule